// File: doc/BRIEF.md
# Instruction Fetch and Next-Address Unit

This block owns the program counter of a single-cycle processor core. On each cycle it presents the word stored at the current program counter and the counter value itself. The word comes from an instruction store modelled as a read-only array. The unit also works out where the next fetch will come from.

Three candidate next addresses are formed every cycle: the sequential one, a PC-relative branch target and a region-relative jump target. Decode logic outside the unit says only whether the current instruction is a branch or a jump. The unit combines the branch request with the ALU zero flag and decides for itself whether the branch is taken. The chosen address is loaded into the counter on the next rising clock edge.

The interface is plain control and data with no handshake. A new instruction is accepted every cycle, and nothing downstream can hold the unit back.

Top module: `ifetch_unit`

## Requirements
- R1: A synchronous, active-high `rst` sampled on a rising edge sets `pc` to 0 after that edge. This holds both at start-up and in the middle of a run.
- R2: `instr` always shows the array word at index (`pc` >> 2) modulo 256, with no clock delay. Word k of the array holds (k × 0x9E3779B1) XOR 0x0F0F5A5A, truncated to 32 bits.
- R3: When `br_sel` and `jmp_sel` are both 0, the next `pc` is `pc` + 4.
- R4: When `br_sel` is 1, `alu_zero` is 1 and `jmp_sel` is 0, the next `pc` is `pc` + 4 + (sign-extended `imm_off` shifted left by 2). This covers both positive and negative offsets.
- R5: When `br_sel` is 1, `alu_zero` is 0 and `jmp_sel` is 0, the next `pc` is `pc` + 4.
- R6: When `jmp_sel` is 1, the next `pc` is the concatenation of bits 31:28 of (`pc` + 4), `jmp_tgt` and two zero bits.
- R7: `jmp_sel` overrides `br_sel`: a jump is taken even when a branch with `alu_zero` = 1 is requested in the same cycle.
- R8: Bits 1:0 of `pc` are 0 in every cycle after reset.
- R9: `alu_zero` has no effect on the next `pc` when `br_sel` is 0.
- R10: All address arithmetic wraps modulo 2^32. A step from 0xFFFFFFFC returns to 0, and a branch from 0 with offset −2 lands on 0xFFFFFFFC.
- R11: The upper four bits of a jump target come from `pc` + 4, not from `pc`. A jump issued at 0x0FFFFFFC therefore lands in the 0x1xxxxxxx region.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the counter |
| br_sel | input | 1 | Current instruction is a conditional branch |
| jmp_sel | input | 1 | Current instruction is an absolute-region jump |
| alu_zero | input | 1 | Equality result from the ALU for the current instruction |
| imm_off | input | 16 | Signed branch offset in words |
| jmp_tgt | input | 26 | Jump target word field |
| instr | output | 32 | Instruction word at the current counter |
| pc | output | 32 | Current program counter |

## Verification
Straight-line steps are issued with `alu_zero` at both levels. This separates a correct sequential path from one that lets the flag leak in. Branches are tried taken and not taken, with positive and negative offsets, which exposes sign-extension and scaling errors. Jumps are issued both alone and together with a taken branch to confirm the priority. A jump from 0x0FFFFFFC shows whether the region bits come from the incremented counter. Negative branches from address 0, the wrap back to 0 and a reset in the middle of a run cover the arithmetic limits. The instruction word is compared on every cycle, including at the top array index.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

  typedef enum logic [1:0] {
    NXT_SEQ = 2'd0,
    NXT_BR  = 2'd1,
    NXT_JMP = 2'd2
  } nxt_sel_e;

  // Fixed content rule for the instruction store (see R2).
  function automatic logic [31:0] rom_word(input logic [31:0] idx);
    logic [31:0] prod;
    prod = idx * 32'h9E37_79B1;
    return prod ^ 32'h0F0F_5A5A;
  endfunction

endpackage

// File: rtl/ifu_take.sv
module ifu_take
  import ifu_pkg::*;
(
  input  logic     br_sel,
  input  logic     jmp_sel,
  input  logic     alu_zero,
  output nxt_sel_e nsel
);
  // Jump wins over branch; a branch is taken only on a zero flag.
  always_comb begin
    if (jmp_sel)               nsel = NXT_JMP;
    else if (br_sel && alu_zero) nsel = NXT_BR;
    else                       nsel = NXT_SEQ;
  end
endmodule

// File: rtl/ifu_next_pc.sv
module ifu_next_pc
  import ifu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int TGT_W  = 26
) (
  input  logic [ADDR_W-1:0] pc_cur,
  input  logic [IMM_W-1:0]  imm_off,
  input  logic [TGT_W-1:0]  jmp_tgt,
  input  nxt_sel_e          nsel,
  output logic [ADDR_W-1:0] pc_next
);
  localparam int EXT_W = ADDR_W - IMM_W - 2;
  localparam int RGN_W = ADDR_W - TGT_W - 2;

  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] br_disp;
  logic [ADDR_W-1:0] br_addr;
  logic [ADDR_W-1:0] jmp_addr;

  assign seq_addr = pc_cur + ADDR_W'(4);
  assign br_disp  = {{EXT_W{imm_off[IMM_W-1]}}, imm_off, 2'b00};
  assign br_addr  = seq_addr + br_disp;
  assign jmp_addr = {seq_addr[ADDR_W-1 -: RGN_W], jmp_tgt, 2'b00};

  always_comb begin
    unique case (nsel)
      NXT_BR:  pc_next = br_addr;
      NXT_JMP: pc_next = jmp_addr;
      default: pc_next = seq_addr;
    endcase
  end
endmodule

// File: rtl/ifu_pc_reg.sv
module ifu_pc_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] pc_next,
  output logic [ADDR_W-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end
endmodule

// File: rtl/ifu_imem.sv
module ifu_imem
  import ifu_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 32
) (
  input  logic [$clog2(DEPTH)-1:0] widx,
  output logic [WORD_W-1:0]        word
);
  logic [WORD_W-1:0] store [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_fill
    assign store[g] = WORD_W'(rom_word(32'(g)));
  end

  assign word = store[widx];
endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit
  import ifu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IMM_W      = 16,
  parameter int TGT_W      = 26,
  parameter int IMEM_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_sel,
  input  logic              jmp_sel,
  input  logic              alu_zero,
  input  logic [IMM_W-1:0]  imm_off,
  input  logic [TGT_W-1:0]  jmp_tgt,
  output logic [31:0]       instr,
  output logic [ADDR_W-1:0] pc
);
  localparam int IDX_W = $clog2(IMEM_DEPTH);

  nxt_sel_e          nsel;
  logic [ADDR_W-1:0] pc_next;
  logic [ADDR_W-1:0] pc_q;

  ifu_take u_take (
    .br_sel   (br_sel),
    .jmp_sel  (jmp_sel),
    .alu_zero (alu_zero),
    .nsel     (nsel)
  );

  ifu_next_pc #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .TGT_W(TGT_W)) u_npc (
    .pc_cur  (pc_q),
    .imm_off (imm_off),
    .jmp_tgt (jmp_tgt),
    .nsel    (nsel),
    .pc_next (pc_next)
  );

  ifu_pc_reg #(.ADDR_W(ADDR_W)) u_pcr (
    .clk     (clk),
    .rst     (rst),
    .pc_next (pc_next),
    .pc_q    (pc_q)
  );

  ifu_imem #(.DEPTH(IMEM_DEPTH), .WORD_W(32)) u_imem (
    .widx (pc_q[IDX_W+1:2]),
    .word (instr)
  );

  assign pc = pc_q;
endmodule

// File: rtl/ifetch_unit_chk.sv
module ifetch_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        br_sel,
  input logic        jmp_sel,
  input logic        alu_zero,
  input logic [15:0] imm_off,
  input logic [25:0] jmp_tgt,
  input logic [31:0] pc
);
  logic [31:0] inc_pc;
  logic        rst_q;
  logic        seen;

  assign inc_pc = pc + 32'd4;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    seen  <= 1'b1;
  end

  // R1
  always @(negedge clk) begin
    if (seen === 1'b1 && rst_q === 1'b1)
      reset_zero_chk: assert (pc == 32'd0);
  end

  // R8
  aligned_chk: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!br_sel && !jmp_sel) |=> pc == $past(inc_pc));

  // R5
  br_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (br_sel && !alu_zero && !jmp_sel) |=> pc == $past(inc_pc));

  // R4
  br_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (br_sel && alu_zero && !jmp_sel) |=>
      pc == $past(inc_pc) + {{14{$past(imm_off[15])}}, $past(imm_off), 2'b00});

  // R6
  jump_chk: assert property (@(posedge clk) disable iff (rst)
    jmp_sel |=> pc == {$past(inc_pc[31:28]), $past(jmp_tgt), 2'b00});

  // R7
  jump_over_br_chk: assert property (@(posedge clk) disable iff (rst)
    (jmp_sel && br_sel && alu_zero) |=> pc[27:2] == $past(jmp_tgt));
endmodule

bind ifetch_unit ifetch_unit_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .br_sel   (br_sel),
  .jmp_sel  (jmp_sel),
  .alu_zero (alu_zero),
  .imm_off  (imm_off),
  .jmp_tgt  (jmp_tgt),
  .pc       (pc)
);

// File: tb/ifetch_unit_test.sv
`timescale 1ns/1ps
module ifetch_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        br_sel = 1'b0;
  logic        jmp_sel = 1'b0;
  logic        alu_zero = 1'b0;
  logic [15:0] imm_off = '0;
  logic [25:0] jmp_tgt = '0;
  logic [31:0] instr;
  logic [31:0] pc;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] m_pc;

  always #2 clk = ~clk;

  ifetch_unit uut (
    .clk(clk), .rst(rst), .br_sel(br_sel), .jmp_sel(jmp_sel),
    .alu_zero(alu_zero), .imm_off(imm_off), .jmp_tgt(jmp_tgt),
    .instr(instr), .pc(pc)
  );

  function automatic logic [31:0] want_word(input logic [31:0] a);
    logic [31:0] k;
    logic [31:0] p;
    k = (a >> 2) % 256;
    p = k * 32'h9E37_79B1;
    return p ^ 32'h0F0F_5A5A;
  endfunction

  task automatic check_out(input string tag);
    tests++;
    if (pc !== m_pc) begin
      fails++;
      $display("FAIL %s pc: actual %h expected %h", tag, pc, m_pc);
    end
    tests++;
    if (instr !== want_word(m_pc)) begin
      fails++;
      $display("FAIL R2 (%s) instr: actual %h expected %h", tag, instr, want_word(m_pc));
    end
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1;
    @(posedge clk);
    m_pc = 32'd0;
    @(negedge clk);
    rst = 1'b0;
    check_out(tag);
  endtask

  task automatic step(input logic b, input logic j, input logic z,
                      input logic [15:0] im, input logic [25:0] t, input string tag);
    logic [31:0] s;
    br_sel = b; jmp_sel = j; alu_zero = z; imm_off = im; jmp_tgt = t;
    @(posedge clk);
    s = m_pc + 32'd4;
    if (j)           m_pc = {s[31:28], t, 2'b00};
    else if (b && z) m_pc = s + ({{16{im[15]}}, im} << 2);
    else             m_pc = s;
    @(negedge clk);
    check_out(tag);
  endtask

  initial begin
    m_pc = 32'd0;
    @(negedge clk);
    do_reset("R1 start");
    step(0, 0, 0, 16'h1234, 26'h0, "R3 seq");
    step(0, 0, 1, 16'h0007, 26'h5, "R9 zero ignored");
    step(0, 0, 1, 16'hFFFF, 26'h3, "R9 zero ignored");
    step(1, 0, 0, 16'h0010, 26'h0, "R5 not taken");
    step(1, 0, 1, 16'h0005, 26'h0, "R4 positive");
    step(1, 0, 1, 16'hFFFD, 26'h0, "R4 negative");
    step(0, 1, 0, 16'h0000, 26'h0000040, "R6 jump");
    step(1, 1, 1, 16'h0100, 26'h0000100, "R7 jump over branch");
    step(0, 1, 1, 16'h0000, 26'h0000000, "R6 jump to 0");
    step(1, 0, 1, 16'hFFFE, 26'h0, "R10 branch below 0");
    step(0, 0, 0, 16'h0000, 26'h0, "R10 wrap to 0");
    step(0, 1, 0, 16'h0000, 26'h3FFFFFF, "R6 jump to region end");
    step(0, 1, 0, 16'h0000, 26'h0000010, "R11 region from pc+4");
    for (int i = 0; i < 60; i++) begin
      step(logic'(i % 3 == 0), logic'(i % 7 == 0), logic'(i % 2 == 0),
           16'(i * 37 - 900), 26'(i * 4099), "R4/R5/R6 mixed");
    end
    step(0, 0, 0, 16'h0, 26'h0, "R3 seq");
    do_reset("R1 mid-run");
    step(0, 0, 0, 16'h0, 26'h0, "R8 after reset");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule